// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Output Divider

This block derives an auxiliary clock output from the main clock. A 3-bit configuration code selects one of five divide ratios (1, 2, 3, 4 or 8) or turns the output off so that it sits low. Code values and their meanings are listed in R1. A power-on reset loads divide-by-4. The output then stays low until a start-up timer has counted a parameterised number of main-clock cycles (7500 by default). When that timer expires, a sticky ready flag rises.

Ratio changes never produce a runt pulse. A new code is accepted only at the end of a complete output period. The output is then held low for a gap of two to eight main-clock cycles before the new waveform starts with a full high phase. Divide-by-1 passes the main clock through a gate. The gate's enable is registered on the falling edge of the main clock, so it only switches while the clock is low. A soft-reset input exists for system use. It leaves the configuration, the ready flag and the running output untouched.

Top module: `clkout_divider`

## Requirements
- R1: Code 3'b000 turns the output off and holds it low. The codes 3'b110 and 3'b111 behave the same way. 3'b001, 3'b010, 3'b011, 3'b100 and 3'b101 select divide ratios 1, 2, 3, 4 and 8.
- R2: Power-on reset (`porRst_n` low) loads the code 3'b100. The soft reset leaves the stored code unchanged.
- R3: After power-on reset is released, the output stays low and `clkReady` is 0 for the first STARTUP_CYCLES-1 rising edges. `clkReady` is 1 after edge STARTUP_CYCLES. The output's first high phase begins at edge STARTUP_CYCLES+1.
- R4: Only power-on reset clears `clkReady`. While `softRst` is high, `clkReady` stays 1 and the output keeps its configured waveform.
- R5: The output, in main-clock cycles (high/low), is 1/1 for divide-by-2, 1/2 for divide-by-3, 2/2 for divide-by-4 and 4/4 for divide-by-8.
- R6: In divide-by-1, the output is high while the main clock is high and low while it is low. The gating enable is registered on the falling edge of the main clock.
- R7: A new code takes effect only after the current output period has completed its low phase, so a high phase already started is never shortened.
- R8: On a change to a new code, a low gap of G = max(2, new ratio) cycles is inserted (G = 2 for off codes). Between two ratios of 2 or more, the last low run is therefore old low length + G cycles.
- R9: Writing an off code drives the output low once the current period and its gap have ended, and the output then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| porRst_n | input | 1 | Power-on reset, active low, asynchronous |
| softRst | input | 1 | Soft reset; no effect on this block's state |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 3 | Configuration code to write |
| clkOut | output | 1 | Divided clock output |
| clkReady | output | 1 | Start-up timer expired (sticky until power-on reset) |

## Verification
A write to `cfgData` is registered on the next rising edge. The control logic then acts on the following period end, so the new waveform appears exactly old-low + G cycles after the last falling edge of the old ratio. The bench first aligns to an output rising edge, writes, and counts low samples up to the first high run of the new length. The ready flag is checked one edge before and at edge STARTUP_CYCLES, and the first high sample one edge later. Output is sampled one time unit after each rising edge; divide-by-1 is also sampled after the falling edge, where it must be low.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int CODE_W  = 3;
  localparam int RATIO_W = 4;
  localparam int CNT_W   = RATIO_W - 1;
  localparam logic [CODE_W-1:0] POR_CODE = 3'b100;

  typedef enum logic [1:0] {ST_HOLD, ST_RUN, ST_GAP, ST_OFF} ctrl_state_e;

  typedef struct packed {
    logic               start;
    logic               run;
    logic               fastReq;
    logic [RATIO_W-1:0] ratio;
  } div_strobe_t;

  function automatic logic [RATIO_W-1:0] ratioOf(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    return RATIO_W'(1);
      3'd2:    return RATIO_W'(2);
      3'd3:    return RATIO_W'(3);
      3'd4:    return RATIO_W'(4);
      3'd5:    return RATIO_W'(8);
      default: return '0;
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] gapOf(input logic [RATIO_W-1:0] r);
    return (r < RATIO_W'(2)) ? RATIO_W'(2) : r;
  endfunction
endpackage

// File: rtl/cdiv_ctrl.sv
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter int STARTUP_CYCLES = 7500
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              softRst,
  input  logic              cfgWe,
  input  logic [CODE_W-1:0] cfgData,
  input  logic              periodEnd,
  output div_strobe_t       stb,
  output logic              clkReady
);
  localparam int TMR_W = $clog2(STARTUP_CYCLES + 1);

  logic [TMR_W-1:0]   tmrCnt;
  logic [CODE_W-1:0]  cfgCode, actCode, pendCode;
  logic [RATIO_W-1:0] gapCnt, cfgRatio, actRatio, pendRatio;
  ctrl_state_e        state;
  logic               fastQ, change, gapDone, launchHold, leaveRun, leaveOff;

  // start-up timer, cleared only by power-on reset
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      tmrCnt   <= '0;
      clkReady <= 1'b0;
    end else if (!clkReady) begin
      if (tmrCnt == TMR_W'(STARTUP_CYCLES - 1)) clkReady <= 1'b1;
      tmrCnt <= tmrCnt + 1'b1;
    end
  end

  // configuration register, loaded to divide-by-4 on power-on only
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n)  cfgCode <= POR_CODE;
    else if (cfgWe) cfgCode <= cfgData;
  end

  always_comb begin
    cfgRatio   = ratioOf(cfgCode);
    actRatio   = ratioOf(actCode);
    pendRatio  = ratioOf(pendCode);
    change     = (cfgCode != actCode);
    gapDone    = (state == ST_GAP) && (gapCnt == '0);
    launchHold = (state == ST_HOLD) && clkReady;
    leaveRun   = (state == ST_RUN) && periodEnd && change;
    leaveOff   = (state == ST_OFF) && change;

    stb.start   = (launchHold && (cfgRatio >= RATIO_W'(2))) ||
                  (gapDone && (pendRatio >= RATIO_W'(2)));
    stb.run     = (state == ST_RUN) && (actRatio >= RATIO_W'(2)) && !leaveRun;
    stb.fastReq = fastQ;
    stb.ratio   = actRatio;
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      state    <= ST_HOLD;
      actCode  <= POR_CODE;
      pendCode <= POR_CODE;
      gapCnt   <= '0;
      fastQ    <= 1'b0;
    end else begin
      case (state)
        ST_HOLD: if (clkReady) begin
          actCode <= cfgCode;
          state   <= (cfgRatio == '0) ? ST_OFF : ST_RUN;
          fastQ   <= (cfgRatio == RATIO_W'(1));
        end
        ST_RUN, ST_OFF: if (leaveRun || leaveOff) begin
          state    <= ST_GAP;
          pendCode <= cfgCode;
          gapCnt   <= gapOf(cfgRatio) - RATIO_W'(1);
          fastQ    <= 1'b0;
        end
        ST_GAP: if (gapCnt == '0) begin
          actCode <= pendCode;
          state   <= (pendRatio == '0) ? ST_OFF : ST_RUN;
          fastQ   <= (pendRatio == RATIO_W'(1));
        end else begin
          gapCnt <= gapCnt - RATIO_W'(1);
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!porRst_n)
    clkReady |=> clkReady); // R4
  AST_SOFT_KEEPS_CFG: assert property (@(posedge clk) disable iff (!porRst_n)
    (softRst && !cfgWe) |=> $stable(cfgCode)); // R2
  AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (!porRst_n)
    (state == ST_RUN && !periodEnd) |=> (state != ST_GAP)); // R7
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!porRst_n)
    (state == ST_GAP && gapCnt != '0) |=> (state == ST_GAP)); // R8
endmodule

// File: rtl/cdiv_datapath.sv
module cdiv_datapath
  import cdiv_pkg::*;
(
  input  logic        clk,
  input  logic        porRst_n,
  input  div_strobe_t stb,
  output logic        periodEnd,
  output logic        clkOut
);
  logic [CNT_W-1:0]   cnt, cntNext;
  logic [RATIO_W-1:0] hiLen, lastIdx, hiRun;
  logic               divOut, fastEn;

  always_comb begin
    hiLen     = stb.ratio >> 1;
    lastIdx   = stb.ratio - RATIO_W'(1);
    periodEnd = ({1'b0, cnt} == lastIdx);
    cntNext   = periodEnd ? '0 : cnt + 1'b1;
  end

  // divided waveform for ratios 2 and above
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      cnt    <= '0;
      divOut <= 1'b0;
    end else if (stb.start) begin
      cnt    <= '0;
      divOut <= 1'b1;
    end else if (stb.run) begin
      cnt    <= cntNext;
      divOut <= ({1'b0, cntNext} < hiLen);
    end else begin
      cnt    <= '0;
      divOut <= 1'b0;
    end
  end

  // divide-by-1 gate enable, changes only while the clock is low
  always_ff @(negedge clk or negedge porRst_n) begin
    if (!porRst_n) fastEn <= 1'b0;
    else           fastEn <= stb.fastReq;
  end

  assign clkOut = divOut | (clk & fastEn);

  // high-run length tracker for the duty check
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n)   hiRun <= '0;
    else if (divOut) hiRun <= hiRun + 1'b1;
    else             hiRun <= '0;
  end

  AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!porRst_n)
    !(divOut && fastEn)); // R6
  AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!porRst_n)
    $fell(divOut) |-> (hiRun == (stb.ratio >> 1))); // R5
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import cdiv_pkg::*;
#(
  parameter int STARTUP_CYCLES = 7500
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              softRst,
  input  logic              cfgWe,
  input  logic [CODE_W-1:0] cfgData,
  output logic              clkOut,
  output logic              clkReady
);
  div_strobe_t stb;
  logic        periodEnd;

  cdiv_ctrl #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_ctrl (
    .clk(clk), .porRst_n(porRst_n), .softRst(softRst), .cfgWe(cfgWe),
    .cfgData(cfgData), .periodEnd(periodEnd), .stb(stb), .clkReady(clkReady)
  );

  cdiv_datapath u_dp (
    .clk(clk), .porRst_n(porRst_n), .stb(stb),
    .periodEnd(periodEnd), .clkOut(clkOut)
  );

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!porRst_n)
    !clkReady |-> !clkOut); // R3
endmodule

// File: tb/clkout_divider_bench.sv
module clkout_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STARTUP    = 7500;

  logic       clk = 1'b0, porRst_n = 1'b0, softRst = 1'b0, cfgWe = 1'b0;
  logic [2:0] cfgData = 3'd0;
  logic       clkOut, clkReady;
  int         checks = 0, fails = 0, cyc = 0;
  bit         done = 1'b0;

  clkout_divider #(.STARTUP_CYCLES(STARTUP)) u_clkout_divider (
    .clk(clk), .porRst_n(porRst_n), .softRst(softRst), .cfgWe(cfgWe),
    .cfgData(cfgData), .clkOut(clkOut), .clkReady(clkReady)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog (run hung) actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int ratioB(input logic [2:0] c);
    case (c) 3'd1: return 1; 3'd2: return 2; 3'd3: return 3; 3'd4: return 4; 3'd5: return 8; default: return 0; endcase
  endfunction
  function automatic int hiB(input logic [2:0] c); return ratioB(c) / 2; endfunction
  function automatic int loB(input logic [2:0] c); return ratioB(c) - ratioB(c) / 2; endfunction
  function automatic int gapB(input logic [2:0] c); return (ratioB(c) < 2) ? 2 : ratioB(c); endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(output logic s);
    @(posedge clk); #1; s = clkOut;
  endtask

  task automatic writeCfg(input logic [2:0] c);
    logic s;
    cfgData = c; cfgWe = 1'b1;
    tick(s);
    cfgWe = 1'b0;
  endtask

  task automatic settle();
    logic s;
    repeat (24) tick(s);
  endtask

  task automatic syncRise();
    logic s, prev;
    tick(prev);
    for (int i = 0; i < 40; i++) begin
      tick(s);
      if (!prev && s) break;
      prev = s;
    end
  endtask

  task automatic measure(input logic [2:0] c, input string req);
    logic s;
    int hi, lo, bad;
    bad = 0;
    if (ratioB(c) == 0) begin
      for (int i = 0; i < 16; i++) begin
        tick(s); if (s) bad++;
        @(negedge clk); #1; if (clkOut) bad++;
      end
      check(bad == 0, req, bad, 0);
    end else if (ratioB(c) == 1) begin
      for (int i = 0; i < 8; i++) begin
        tick(s); if (!s) bad++;
        @(negedge clk); #1; if (clkOut) bad++;
      end
      check(bad == 0, req, bad, 0);
    end else begin
      syncRise();
      hi = 1;
      tick(s);
      while (s && hi < 40) begin hi++; tick(s); end
      lo = 1;
      tick(s);
      while (!s && lo < 40) begin lo++; tick(s); end
      check(hi == hiB(c), req, hi, hiB(c));
      check(lo == loB(c), req, lo, loB(c));
    end
  endtask

  // old code must be running; its high length differs from the new one
  task automatic transition(input logic [2:0] oldC, input logic [2:0] newC);
    logic s, prev;
    int lowRun, hi;
    bit found;
    syncRise();
    cfgData = newC; cfgWe = 1'b1;
    prev = 1'b1; lowRun = 0; found = 1'b0;
    for (int i = 0; i < 80 && !found; i++) begin
      tick(s);
      cfgWe = 1'b0;
      if (!s) begin
        lowRun = prev ? 1 : lowRun + 1;
        prev = 1'b0;
      end else if (!prev) begin
        hi = 1;
        tick(s);
        while (s && hi < 40) begin hi++; tick(s); end
        if (hi == hiB(newC)) begin
          found = 1'b1;
          check(lowRun == loB(oldC) + gapB(newC), "R8 transition low gap",
                lowRun, loB(oldC) + gapB(newC));
        end
        lowRun = 1; prev = 1'b0;
      end else begin
        prev = 1'b1;
      end
    end
    check(found, "R8 new ratio appears", found, 1);
  endtask

  task automatic startup();
    logic s;
    bit anyHigh;
    anyHigh = 1'b0;
    @(negedge clk); porRst_n = 1'b1;
    for (int k = 1; k < STARTUP; k++) begin tick(s); anyHigh |= s; end
    check(!clkReady, "R3 ready one edge early", clkReady, 0);
    check(!anyHigh, "R3 output low during start-up", anyHigh, 0);
    tick(s);
    check(clkReady, "R3 ready at expiry", clkReady, 1);
    check(!s, "R3 still low at expiry edge", s, 0);
    tick(s);
    check(s, "R3 first high edge after expiry", s, 1);
  endtask

  initial begin
    logic s;
    logic [2:0] code;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    #1;
    check(!clkOut && !clkReady, "R3 reset state", {clkOut, clkReady}, 0);
    startup();
    measure(3'd4, "R2 power-on divide-by-4 (R5)");

    transition(3'd4, 3'd5);
    measure(3'd5, "R5 divide-by-8");
    transition(3'd5, 3'd3);
    measure(3'd3, "R5 divide-by-3");
    transition(3'd3, 3'd4);
    measure(3'd4, "R5 divide-by-4 after change");

    writeCfg(3'd2); settle();
    measure(3'd2, "R5 divide-by-2");
    writeCfg(3'd1); settle();
    measure(3'd1, "R6 divide-by-1 follows clock");
    writeCfg(3'd0); settle();
    measure(3'd0, "R1 code 000 off");
    writeCfg(3'd6); settle();
    measure(3'd6, "R1 reserved code off");
    writeCfg(3'd3); settle();

    softRst = 1'b1;
    measure(3'd3, "R4 output runs through soft reset");
    check(clkReady, "R4 ready kept in soft reset", clkReady, 1);
    softRst = 1'b0;
    measure(3'd3, "R2 code kept after soft reset");

    writeCfg(3'd4); settle();
    syncRise();
    cfgData = 3'd0; cfgWe = 1'b1;
    tick(s);
    cfgWe = 1'b0;
    check(s, "R7 started high phase not cut", s, 1);
    repeat (6) tick(s);
    measure(3'd0, "R9 off after period end");

    for (int n = 0; n < 10; n++) begin
      code = 3'($urandom_range(7, 0));
      writeCfg(code); settle();
      measure(code, "R1 random code");
    end

    writeCfg(3'd5); settle();
    porRst_n = 1'b0;
    tick(s);
    check(!clkReady && !s, "R4 power-on clears ready", {clkReady, s}, 0);
    startup();
    measure(3'd4, "R2 power-on restores divide-by-4");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule